// File: doc/BRIEF.md
# Mode-Dependent Shadow Integer Register File

This block is a 64-bit integer register file with thirty-two architectural entries and a second bank of eight shadow entries. While the core runs in privileged handler mode and the shadow-enable bit is on, eight architectural register numbers (8 to 14, and 25) are steered to the shadow bank. Handler code can then use those numbers as private scratch without saving the interrupted program's values. Outside that condition, the same numbers reach the normal bank. Register numbers outside the overlaid set always reach the normal bank.

There are two combinational read ports and one write port. The write port commits on the rising clock edge. Each port applies the overlay decision on its own, on every access. A read that names the same physical entry as the write in the same cycle returns the incoming write data through a bypass. The core raises `flow_tail` during the closing two cycles of a handler flow. While it is high, a write that would land in the shadow bank is dropped.

The shadow-enable bit is a two-state machine with states SH_ON (the reset state) and SH_OFF. A cycle with `shen_we` high takes the transition to SH_ON when `shen_d` is 1 and to SH_OFF when `shen_d` is 0. The new state applies from the next cycle. From that state and the inputs, an output process forms one of three access views:
- VW_FLAT: no overlay. This view applies in SH_OFF, or when `priv_mode` is low.
- VW_OVERLAY: the overlay is active. This view applies in SH_ON with `priv_mode` high and `flow_tail` low.
- VW_OVERLAY_LOCK: the overlay is active and writes to the shadow bank are blocked. This view applies in SH_ON with `priv_mode` and `flow_tail` both high.

Top module: `shadow_regfile`

## Requirements
- R1: Every entry is 64 bits wide. Reset clears both banks, so any read after reset returns zero.
- R2: Register number 31 always reads as zero. A write to it changes nothing in any mode.
- R3: The shadow-enable bit is on after reset. A cycle with `shen_we` high loads `shen_d`, and the new value applies from the next cycle onward.
- R4: When `priv_mode` is high and shadow-enable is on, register numbers 8 to 14 access shadow slots 0 to 6, and register number 25 accesses shadow slot 7.
- R5: When `priv_mode` is low or shadow-enable is off, register numbers 8 to 14 and 25 access the normal bank. All other register numbers access the normal bank in every mode.
- R6: When `flow_tail` is high and the overlay is active, a write to an overlaid register number is dropped. It changes neither bank and is not bypassed.
- R7: `flow_tail` has no effect on writes to non-overlaid register numbers, or on any write while the overlay is inactive.
- R8: A read of the entry being written in the same cycle returns `wr_data`.
- R9: Each read port and the write port apply the overlay mapping independently. A value written to a shadow slot is not visible at the same register number once the overlay is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 1 | Core is in privileged handler mode |
| flow_tail | input | 1 | High during the closing two cycles of a handler flow |
| shen_we | input | 1 | Load the shadow-enable bit |
| shen_d | input | 1 | New shadow-enable value |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Write register number |
| wr_data | input | 64 | Write data |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | 64 | Read port A data (combinational) |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | 64 | Read port B data (combinational) |

## Verification
A wrong shadow-enable state or a wrong view shows up at the read ports on the same cycle as the access. The read returns a value from the other bank: for example, zero from an untouched shadow slot where a normal-bank value was expected. A write that leaked into the wrong bank during the tail cycles is invisible until that register number is read back under the other view. The bench therefore re-reads each register number under both views after every mode change and after every tail write. A late or early load of the enable bit is caught by reads in the cycle of the load and in the cycle after it.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic {
        SH_OFF = 1'b0,
        SH_ON  = 1'b1
    } shen_state_t;

    typedef enum logic [1:0] {
        VW_FLAT         = 2'd0,
        VW_OVERLAY      = 2'd1,
        VW_OVERLAY_LOCK = 2'd2
    } view_t;

endpackage

// File: rtl/srf_ctrl.sv
module srf_ctrl
    import srf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  priv_mode,
    input  logic  flow_tail,
    input  logic  shen_we,
    input  logic  shen_d,
    output view_t view
);

    shen_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_ON:  if (shen_we && !shen_d) st_d = SH_OFF;
            SH_OFF: if (shen_we &&  shen_d) st_d = SH_ON;
            default: st_d = SH_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SH_ON;
        else        st_q <= st_d;
    end

    always_comb begin
        view = VW_FLAT;
        unique case (st_q)
            SH_OFF: view = VW_FLAT;
            SH_ON: begin
                if (!priv_mode)     view = VW_FLAT;
                else if (flow_tail) view = VW_OVERLAY_LOCK;
                else                view = VW_OVERLAY;
            end
            default: view = VW_FLAT;
        endcase
    end

    AST_SHEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        shen_we |=> (st_q == ($past(shen_d) ? SH_ON : SH_OFF))); // R3
    AST_SHEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shen_we |=> $stable(st_q)); // R3

endmodule

// File: rtl/srf_map.sv
module srf_map #(
    parameter int AW    = 5,
    parameter int BASE  = 8,
    parameter int RUN   = 7,
    parameter int EXTRA = 25,
    parameter int SW    = 3
) (
    input  logic [AW-1:0] addr,
    input  logic          ovl,
    output logic          hit,
    output logic [SW-1:0] slot,
    output logic          is_zero
);

    localparam logic [AW-1:0] BASE_A  = AW'(BASE);
    localparam logic [AW-1:0] END_A   = AW'(BASE + RUN);
    localparam logic [AW-1:0] EXTRA_A = AW'(EXTRA);

    logic in_run, is_extra;
    logic [AW-1:0] off;

    always_comb begin
        in_run   = (addr >= BASE_A) && (addr < END_A);
        is_extra = (addr == EXTRA_A);
        off      = addr - BASE_A;
        is_zero  = (addr == '1);
        hit      = ovl && (in_run || is_extra);
        slot     = is_extra ? SW'(RUN) : off[SW-1:0];
    end

endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int DW    = 64,
    parameter int DEPTH = 32,
    parameter int NRD   = 2,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import srf_pkg::*;
#(
    parameter int DW     = 64,
    parameter int NREG   = 32,
    parameter int SBASE  = 8,
    parameter int SRUN   = 7,
    parameter int SEXTRA = 25,
    localparam int AW    = $clog2(NREG),
    localparam int NSHD  = SRUN + 1,
    localparam int SW    = $clog2(NSHD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          priv_mode,
    input  logic          flow_tail,
    input  logic          shen_we,
    input  logic          shen_d,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_b_data
);

    localparam int NRD  = 2;
    localparam int NACC = NRD + 1;   // index NRD is the write port

    view_t view;
    logic  ovl, lock;

    srf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_mode (priv_mode),
        .flow_tail (flow_tail),
        .shen_we   (shen_we),
        .shen_d    (shen_d),
        .view      (view)
    );

    assign ovl  = (view != VW_FLAT);
    assign lock = (view == VW_OVERLAY_LOCK);

    logic [AW-1:0] acc_addr [NACC];
    logic          acc_hit  [NACC];
    logic [SW-1:0] acc_slot [NACC];
    logic          acc_zero [NACC];

    assign acc_addr[0]   = rd_a_addr;
    assign acc_addr[1]   = rd_b_addr;
    assign acc_addr[NRD] = wr_addr;

    for (genvar p = 0; p < NACC; p++) begin : g_map
        srf_map #(.AW(AW), .BASE(SBASE), .RUN(SRUN), .EXTRA(SEXTRA), .SW(SW)) u_map (
            .addr    (acc_addr[p]),
            .ovl     (ovl),
            .hit     (acc_hit[p]),
            .slot    (acc_slot[p]),
            .is_zero (acc_zero[p])
        );
    end

    logic wr_ok, nrm_we, sh_we;
    assign wr_ok  = wr_en && !acc_zero[NRD] && !(acc_hit[NRD] && lock);
    assign nrm_we = wr_ok && !acc_hit[NRD];
    assign sh_we  = wr_ok &&  acc_hit[NRD];

    logic [AW-1:0] nrm_ra [NRD];
    logic [SW-1:0] shd_ra [NRD];
    logic [DW-1:0] nrm_rd [NRD];
    logic [DW-1:0] shd_rd [NRD];
    logic [DW-1:0] rd_out [NRD];

    srf_bank #(.DW(DW), .DEPTH(NREG), .NRD(NRD)) u_normal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (nrm_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (nrm_ra),
        .rdata (nrm_rd)
    );

    srf_bank #(.DW(DW), .DEPTH(NSHD), .NRD(NRD)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sh_we),
        .waddr (acc_slot[NRD]),
        .wdata (wr_data),
        .raddr (shd_ra),
        .rdata (shd_rd)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rdmux
        logic same;
        assign nrm_ra[p] = acc_addr[p];
        assign shd_ra[p] = acc_slot[p];
        always_comb begin
            if (acc_hit[p]) same = acc_hit[NRD] && (acc_slot[NRD] == acc_slot[p]);
            else            same = !acc_hit[NRD] && (wr_addr == acc_addr[p]);
            if (acc_zero[p])          rd_out[p] = '0;
            else if (wr_ok && same)   rd_out[p] = wr_data;
            else if (acc_hit[p])      rd_out[p] = shd_rd[p];
            else                      rd_out[p] = nrm_rd[p];
        end
    end

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '1) |-> (rd_a_data == '0)); // R2
    AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nrm_we && sh_we)); // R4
    AST_FLAT_NO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_mode |-> !sh_we); // R5
    AST_TAIL_BLOCKS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode && flow_tail) |-> !sh_we); // R6
    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flow_tail && wr_addr == rd_a_addr && wr_addr != '1)
        |-> (rd_a_data == wr_data)); // R8

endmodule

// File: tb/shadow_regfile_test.sv
module shadow_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_mode = 1'b0, flow_tail = 1'b0, shen_we = 1'b0, shen_d = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_a_addr = '0, rd_b_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_a_data, rd_b_data;

    always #5 clk = ~clk;

    shadow_regfile uut (
        .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .flow_tail(flow_tail),
        .shen_we(shen_we), .shen_d(shen_d), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    logic [63:0] q_ea [$];
    logic [63:0] q_eb [$];
    string       q_tag [$];
    int vectors = 0, miscompares = 0;
    bit done = 0;

    localparam logic [63:0] VA = 64'hA5A5_0000_1111_2222;
    localparam logic [63:0] VB = 64'h8000_0000_0000_0001;
    localparam logic [63:0] VC = 64'hC0DE_CAFE_F00D_BEEF;
    localparam logic [63:0] VD = 64'h0000_0000_DDDD_DDDD;
    localparam logic [63:0] VE = 64'hEEEE_EEEE_EEEE_EEEE;
    localparam logic [63:0] VF = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] VG = 64'hFFFF_FFFF_0000_0009;
    localparam logic [63:0] VH = 64'h3131_3131_3131_3131;
    localparam logic [63:0] VJ = 64'h7777_0000_0000_000A;
    localparam logic [63:0] VK = 64'h0E0E_0E0E_0E0E_0E0E;
    localparam logic [63:0] VL = 64'h4C4C_4C4C_4C4C_4C4C;

    // driver: one call per cycle; drives at the falling edge and queues expectations
    task automatic cyc(input logic we, input logic [4:0] wa, input logic [63:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb,
                       input logic pm, input logic tl, input logic sw, input logic sd,
                       input logic [63:0] ea, input logic [63:0] eb, input string tg);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        priv_mode = pm; flow_tail = tl; shen_we = sw; shen_d = sd;
        q_ea.push_back(ea); q_eb.push_back(eb); q_tag.push_back(tg);
    endtask

    // monitor: compares mid-cycle, after inputs settle and before the next edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (q_tag.size() > 0) begin
                logic [63:0] ea, eb;
                string tg;
                ea = q_ea.pop_front(); eb = q_eb.pop_front(); tg = q_tag.pop_front();
                vectors += 2;
                if (rd_a_data !== ea) begin
                    miscompares++;
                    $display("FAIL %s port A: got %h expected %h", tg, rd_a_data, ea);
                end
                if (rd_b_data !== eb) begin
                    miscompares++;
                    $display("FAIL %s port B: got %h expected %h", tg, rd_b_data, eb);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //  we  wa  wd   ra  rb  pm tl sw sd  expA expB  tag
        cyc(0, 0,  0,   8,  25, 0, 0, 0, 0, 0,  0,  "R1 reset clears");
        cyc(1, 8,  VA,  8,  25, 0, 0, 0, 0, VA, 0,  "R8 bypass normal");
        cyc(1, 25, VB,  8,  25, 0, 0, 0, 0, VA, VB, "R8 bypass port B");
        cyc(1, 8,  VC,  8,  25, 1, 0, 0, 0, VC, 0,  "R3 R4 overlay on after reset");
        cyc(1, 3,  VD,  8,  3,  1, 0, 0, 0, VC, VD, "R5 non-overlaid in handler");
        cyc(0, 0,  0,   8,  3,  0, 0, 0, 0, VA, VD, "R5 flat view");
        cyc(1, 25, VE,  25, 8,  1, 1, 0, 0, 0,  VC, "R6 tail write not bypassed");
        cyc(0, 0,  0,   25, 9,  1, 0, 0, 0, 0,  0,  "R6 shadow untouched");
        cyc(0, 0,  0,   25, 31, 0, 0, 0, 0, VB, 0,  "R6 normal untouched");
        cyc(1, 4,  VF,  4,  8,  1, 1, 0, 0, VF, VC, "R7 tail non-overlaid write");
        cyc(1, 9,  VG,  9,  4,  0, 1, 0, 0, VG, VF, "R7 tail flat write");
        cyc(1, 31, VH,  31, 31, 1, 0, 0, 0, 0,  0,  "R2 zero register write");
        cyc(0, 0,  0,   8,  31, 1, 0, 1, 0, VC, 0,  "R3 R2 disable not yet applied");
        cyc(1, 10, VJ,  8,  9,  1, 0, 0, 0, VA, VG, "R3 disable applied");
        cyc(0, 0,  0,   10, 14, 0, 0, 0, 0, VJ, 0,  "R5 write under disable hit normal");
        cyc(0, 0,  0,   10, 14, 0, 0, 1, 1, VJ, 0,  "R3 re-enable");
        cyc(0, 0,  0,   10, 25, 1, 0, 0, 0, 0,  0,  "R4 slot 2 and slot 7 empty");
        cyc(1, 14, VK,  14, 13, 1, 0, 0, 0, VK, 0,  "R9 shadow write bypass");
        cyc(0, 0,  0,   14, 10, 1, 0, 0, 0, VK, 0,  "R9 shadow read");
        cyc(0, 0,  0,   14, 8,  0, 0, 0, 0, 0,  VA, "R9 normal r14 separate");
        cyc(1, 8,  VL,  8,  25, 1, 1, 0, 0, VC, 0,  "R6 tail write r8 dropped");
        cyc(0, 0,  0,   8,  8,  1, 0, 0, 0, VC, VC, "R6 r8 shadow kept");
        cyc(0, 0,  0,   8,  31, 0, 0, 0, 0, VA, 0,  "R6 R2 r8 normal kept");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule